// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a four-bit counter made of two sections that advance on their own count strobes. The low section has a single bit and divides by two: it toggles on every falling edge of `strobe_a`. The high section is a three-bit modulo-5 counter. In independent mode it steps through 0 to 4 on every falling edge of `strobe_b`. Both strobes are ordinary inputs sampled in the single system clock domain. A falling edge is seen when the input was high at one rising clock edge and is low at the next.

The sections share nothing unless `chain_en` is high. In that mode the carry out of the low section drives the high section, and `strobe_b` has no effect. The value `q_lo + 2*q_hi` then counts 0 to 9 in BCD and wraps, which divides `strobe_a` by ten. The low section alone gives divide-by-2, and the high section alone gives divide-by-5. Two synchronous controls force the outputs: `clear_zero` sets them to zero and `set_nine` loads decimal nine. If both are high, the clear wins.

Top module: `bcd_dual_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q_lo` and `q_hi` become 0 at that edge and the strobe history is cleared. After reset, a strobe that is first sampled low is therefore not a count event.
- R2: A falling edge of `strobe_a` toggles `q_lo`. It takes effect at the first rising clock edge at which `strobe_a` is sampled low after having been sampled high at the previous edge. A rising edge of `strobe_a`, or a strobe held at one level, leaves `q_lo` unchanged.
- R3: In independent mode (`chain_en` = 0), each falling edge of `strobe_b`, detected in the same way, moves `q_hi` through 0, 1, 2, 3, 4 and back to 0. `q_hi` bit 0 is QB, bit 1 is QC and bit 2 is QD.
- R4: In independent mode, a `strobe_a` event never changes `q_hi` and a `strobe_b` event never changes `q_lo`.
- R5: In chained mode (`chain_en` = 1), `strobe_b` is ignored. `q_hi` advances at exactly those clock edges at which `q_lo` toggles from 1 to 0.
- R6: `clear_zero` at a rising edge sets both outputs to 0 at that edge, ignores count events in that cycle, and takes priority over `set_nine`.
- R7: `set_nine` without `clear_zero` at a rising edge loads `q_lo` = 1 and `q_hi` = 4 (QD QC QB QA = 1001) and ignores count events in that cycle.
- R8: In chained mode, successive `strobe_a` falling edges from zero make `q_lo + 2*q_hi` read 1, 2, …, 9 and then 0, so the counter has modulus ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | Count strobe of the divide-by-2 section (falling edge counts) |
| strobe_b | input | 1 | Count strobe of the divide-by-5 section (falling edge counts) |
| chain_en | input | 1 | 1: carry of the low section drives the high section |
| clear_zero | input | 1 | Synchronous force to zero (higher priority) |
| set_nine | input | 1 | Synchronous force to decimal nine |
| q_lo | output | 1 | QA, divide-by-2 output |
| q_hi | output | HI_W (3) | QD QC QB, modulo-HI_MOD section state |

## Verification
The bench builds the block with its default parameters: a modulo-5 high section that is three bits wide, so together with the low bit the counter is a decade counter. With a three-bit section, the wrap from state 4 and the decimal-nine preset value can be reached from the pins. Random strobes, mode changes and forcing controls are checked on every cycle against a model written from the requirements. This covers simultaneous events on both strobes and clear and set arriving together. A directed pass in chained mode walks the full decimal sequence twice.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef struct packed {
    logic zero;
    logic preset;
    logic ev;
  } stage_ctl_t;
endpackage

// File: rtl/edge_fall.sv
module edge_fall #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] fall
);
  logic [N-1:0] hist;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) hist[i] <= 1'b0;
      else     hist[i] <= din[i];
    end
    assign fall[i] = hist[i] & ~din[i];
  end
endmodule

// File: rtl/count_stage.sv
module count_stage
  import bcd_pkg::*;
#(
  parameter int MOD    = 5,
  parameter int PRESET = MOD - 1,
  localparam int W     = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  stage_ctl_t   ctl,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  if (MOD == 2) begin : g_toggle
    assign nxt = ~q;
  end else begin : g_modn
    assign nxt = (q >= W'(MOD - 1)) ? '0 : q + W'(1);
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (ctl.zero)
      q < W'(MOD)); // R3
  end

  always_ff @(posedge clk) begin
    if (ctl.zero)        q <= '0;
    else if (ctl.preset) q <= W'(PRESET);
    else if (ctl.ev)     q <= nxt;
  end

  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (ctl.zero)
    (!ctl.ev && !ctl.preset) |=> $stable(q)); // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (ctl.zero)
    (ctl.ev && !ctl.preset && q == W'(MOD - 1)) |=> q == '0); // R3
  AST_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (ctl.zero)
    (ctl.ev && !ctl.preset) |=> q != $past(q)); // R2
endmodule

// File: rtl/bcd_dual_counter.sv
module bcd_dual_counter
  import bcd_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W  = $clog2(HI_MOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe_a,
  input  logic            strobe_b,
  input  logic            chain_en,
  input  logic            clear_zero,
  input  logic            set_nine,
  output logic            q_lo,
  output logic [HI_W-1:0] q_hi
);
  logic [1:0] fall;
  logic       carry;
  stage_ctl_t ctl_lo, ctl_hi;

  edge_fall #(.N(2)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .din  ({strobe_b, strobe_a}),
    .fall (fall)
  );

  assign carry = fall[0] & q_lo;

  always_comb begin
    ctl_lo.zero   = rst | clear_zero;
    ctl_lo.preset = set_nine;
    ctl_lo.ev     = fall[0];
    ctl_hi.zero   = rst | clear_zero;
    ctl_hi.preset = set_nine;
    ctl_hi.ev     = chain_en ? carry : fall[1];
  end

  count_stage #(.MOD(2), .PRESET(1)) u_lo (
    .clk (clk),
    .ctl (ctl_lo),
    .q   (q_lo)
  );

  count_stage #(.MOD(HI_MOD), .PRESET(HI_MOD - 1)) u_hi (
    .clk (clk),
    .ctl (ctl_hi),
    .q   (q_hi)
  );

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear_zero |=> (!q_lo && q_hi == '0)); // R6
  AST_SET_NINE: assert property (@(posedge clk) disable iff (rst)
    (set_nine && !clear_zero) |=> (q_lo && q_hi == HI_W'(HI_MOD - 1))); // R7
  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    (chain_en && !clear_zero && !set_nine && fall[0] && q_lo) |=> q_hi != $past(q_hi)); // R5
  AST_CHAIN_IGNORES_B: assert property (@(posedge clk) disable iff (rst)
    (chain_en && !clear_zero && !set_nine && !(fall[0] && q_lo)) |=> $stable(q_hi)); // R5
  AST_SPLIT_HI: assert property (@(posedge clk) disable iff (rst)
    (!chain_en && !clear_zero && !set_nine && !fall[1]) |=> $stable(q_hi)); // R4
  AST_SPLIT_LO: assert property (@(posedge clk) disable iff (rst)
    (!clear_zero && !set_nine && !fall[0]) |=> $stable(q_lo)); // R4
endmodule

// File: tb/bcd_dual_counter_test.sv
module bcd_dual_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_a = 1'b0, strobe_b = 1'b0, chain_en = 1'b0;
  logic       clear_zero = 1'b0, set_nine = 1'b0;
  logic       q_lo;
  logic [2:0] q_hi;

  int checks = 0, fails = 0;
  logic done = 1'b0;
  logic pa = 1'b0, pb = 1'b0;
  logic e_lo = 1'b0;
  logic [2:0] e_hi = 3'd0;

  always #2 clk = ~clk;

  bcd_dual_counter uut (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .chain_en(chain_en), .clear_zero(clear_zero), .set_nine(set_nine),
    .q_lo(q_lo), .q_hi(q_hi)
  );

  function automatic logic [2:0] hi_next(input logic [2:0] v);
    return (v >= 3'd4) ? 3'd0 : v + 3'd1;
  endfunction

  function automatic string pick_tag(input logic r, c, s, ch, fa, fb);
    if (r) return "R1";
    if (c) return "R6";
    if (s) return "R7";
    if (ch) return "R5";
    if (fa != fb) return "R4";
    if (fb) return "R3";
    return "R2";
  endfunction

  task automatic step(input logic r, a, b, ch, c, s);
    logic fa, fb, evb;
    string tag;
    @(negedge clk);
    rst = r; strobe_a = a; strobe_b = b; chain_en = ch;
    clear_zero = c; set_nine = s;
    fa = pa & ~a;
    fb = pb & ~b;
    tag = pick_tag(r, c, s, ch, fa, fb);
    if (r || c) begin
      e_lo = 1'b0; e_hi = 3'd0;
    end else if (s) begin
      e_lo = 1'b1; e_hi = 3'd4;
    end else begin
      evb = ch ? (fa & e_lo) : fb;
      if (fa) e_lo = ~e_lo;
      if (evb) e_hi = hi_next(e_hi);
    end
    pa = r ? 1'b0 : a;
    pb = r ? 1'b0 : b;
    @(posedge clk);
    #1;
    checks++;
    if (q_lo !== e_lo || q_hi !== e_hi) begin
      fails++;
      $display("FAIL %s: got lo=%0b hi=%0d expected lo=%0b hi=%0d",
               tag, q_lo, q_hi, e_lo, e_hi);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0);
    // R1: a strobe first seen low after reset is not an event
    step(0, 0, 0, 0, 0, 0);
    // R2: falling edge toggles, rising and steady do not
    step(0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R3: walk high section through wrap
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0);
    end
    // R6 and R7: clear beats set, set loads nine
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 1, 1, 0, 1, 0);
    // R8: chained decade sequence, twice round
    step(0, 0, 0, 1, 1, 0);
    for (int i = 1; i <= 20; i++) begin
      step(0, 1, 1, 1, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      checks++;
      if ((32'(q_lo) + 2 * 32'(q_hi)) != (i % 10)) begin
        fails++;
        $display("FAIL R8: got %0d expected %0d",
                 32'(q_lo) + 2 * 32'(q_hi), i % 10);
      end
    end
    // random mix of all controls
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] rv;
      rv = 8'($urandom);
      step((rv[7:2] == 6'd0), 1'($urandom), 1'($urandom), (i / 500) % 2 == 1,
           ($urandom % 40) == 0, ($urandom % 30) == 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule